// File: doc/BRIEF.md
# Vector Element Issue Packer

This block turns a single vector operation into scalar element operations. It issues them four at a time into a fixed group of scalar issue slots. Elements are numbered contiguously from zero up to VL-1. Each cycle, the next four element numbers go into slots 0 to 3 in ascending order, whatever row structure the program has in mind.

Take a vector of twelve elements seen as four rows of three. The first group holds all of row 0 and the first element of row 1. The second group holds the rest of row 1 and the first two elements of row 2. The third group holds the last four elements. The whole vector therefore issues in three cycles, with no transpose or reshaping of the data.

A descriptor carries the operation tag, VL and three base register indices (destination, source A, source B). It is accepted with a valid/ready handshake. Each group is offered downstream with a valid/ready handshake of its own.

Top module: `vpack_issue`

## Requirements
- R1: After reset, out_valid is 0, every slot_valid bit is 0 and in_ready is 1.
- R2: In group g of a descriptor (g counted from 0), slot k carries element index 4*g+k. Groups follow one another without gaps or repeats.
- R3: A descriptor with VL=12 produces exactly three groups with all four slots valid in each. out_last is set on the third group only.
- R4: The final group has out_last=1, and in it the slots whose element index is VL or more have slot_valid=0. Every group before the final one has all four slots valid and out_last=0.
- R5: For every valid slot, slot_dst, slot_srca and slot_srcb equal the matching base index plus the element index, modulo 64 (6-bit register indices).
- R6: While out_valid=1 and out_ready=0, the presented group stays unchanged in the following cycle.
- R7: While a descriptor is being issued, in_ready is 0. A descriptor offered during that time is not taken, and the groups of the current one continue unchanged.
- R8: A descriptor with VL=0 is accepted, produces no group, and in_ready stays 1.
- R9: The number of groups equals ceil(VL/4) for VL from 1 to 64. out_op carries the accepted opcode tag on every group.
- R10: The valid slots of any group form a run starting at slot 0, and out_valid=0 implies all slot_valid bits are 0.

Slot fields are packed into flat vectors, with slot k at bits [k*W +: W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Packer idle, descriptor can be taken |
| in_op | input | 4 | Opcode tag |
| in_vl | input | 7 | Vector length, 0 to 64 |
| in_dst | input | 6 | Destination base register index |
| in_srca | input | 6 | Source A base register index |
| in_srcb | input | 6 | Source B base register index |
| out_valid | output | 1 | Issue group presented |
| out_ready | input | 1 | Downstream takes the group |
| out_op | output | 4 | Opcode tag of the group |
| out_last | output | 1 | Group is the final one of the descriptor |
| slot_valid | output | 4 | Per-slot valid bits |
| slot_elem | output | 24 | Per-slot element index, 6 bits each |
| slot_dst | output | 24 | Per-slot destination register, 6 bits each |
| slot_srca | output | 24 | Per-slot source A register, 6 bits each |
| slot_srcb | output | 24 | Per-slot source B register, 6 bits each |

## Verification
The assertions assume that in_vl never exceeds 64 and that out_ready is a plain level with no dependence on the slot contents. Above 64, the element counter and the 6-bit element index no longer match. The stimulus draws VL only from 0 to 64 and forces 0, 1, 3, 4, 5, 12 and 64 as directed cases. It drives out_ready from an independent random draw each cycle. While a vector is being issued, it sometimes offers a conflicting descriptor, and it always withdraws that descriptor before the packer returns to idle, so a stray descriptor is never taken by accident.

// File: rtl/vpack_pkg.sv
package vpack_pkg;
    parameter int LANES_DEF  = 4;
    parameter int MAX_VL_DEF = 64;
    parameter int RIDX_W_DEF = 6;
    parameter int OP_W_DEF   = 4;
endpackage

// File: rtl/vpack_slot.sv
module vpack_slot #(
    parameter int LANE   = 0,
    parameter int VL_W   = 7,
    parameter int EIDX_W = 6,
    parameter int RIDX_W = 6
) (
    input  logic              busy,
    input  logic [VL_W-1:0]   cnt,
    input  logic [VL_W-1:0]   vl,
    input  logic [RIDX_W-1:0] dst_base,
    input  logic [RIDX_W-1:0] srca_base,
    input  logic [RIDX_W-1:0] srcb_base,
    output logic              valid,
    output logic [EIDX_W-1:0] elem,
    output logic [RIDX_W-1:0] dst,
    output logic [RIDX_W-1:0] srca,
    output logic [RIDX_W-1:0] srcb
);
    // element number held by this slot, one bit wider so no wrap occurs
    logic [VL_W:0]     elem_full;
    logic [RIDX_W-1:0] offs;

    always_comb begin
        elem_full = {1'b0, cnt} + (VL_W+1)'(LANE);
        valid     = busy && (elem_full < {1'b0, vl});
        offs      = RIDX_W'(elem_full);
        elem      = valid ? EIDX_W'(elem_full) : '0;
        dst       = valid ? dst_base  + offs : '0;
        srca      = valid ? srca_base + offs : '0;
        srcb      = valid ? srcb_base + offs : '0;
    end
endmodule

// File: rtl/vpack_ctrl.sv
module vpack_ctrl #(
    parameter int LANES  = 4,
    parameter int VL_W   = 7,
    parameter int RIDX_W = 6,
    parameter int OP_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_op,
    input  logic [VL_W-1:0]   in_vl,
    input  logic [RIDX_W-1:0] in_dst,
    input  logic [RIDX_W-1:0] in_srca,
    input  logic [RIDX_W-1:0] in_srcb,
    input  logic              out_ready,
    output logic              busy,
    output logic              last,
    output logic [VL_W-1:0]   cnt,
    output logic [VL_W-1:0]   vl,
    output logic [OP_W-1:0]   op,
    output logic [RIDX_W-1:0] dst_base,
    output logic [RIDX_W-1:0] srca_base,
    output logic [RIDX_W-1:0] srcb_base
);
    typedef struct packed {
        logic              busy;
        logic [VL_W-1:0]   cnt;
        logic [VL_W-1:0]   vl;
        logic [OP_W-1:0]   op;
        logic [RIDX_W-1:0] dst;
        logic [RIDX_W-1:0] srca;
        logic [RIDX_W-1:0] srcb;
    } st_t;

    st_t st_d, st_q;
    logic last_c;

    always_comb begin
        last_c = st_q.busy &&
                 (({1'b0, st_q.cnt} + (VL_W+1)'(LANES)) >= {1'b0, st_q.vl});
        st_d = st_q;
        if (in_valid && !st_q.busy) begin
            // a zero-length descriptor leaves the packer idle
            st_d.busy = (in_vl != '0);
            st_d.cnt  = '0;
            st_d.vl   = in_vl;
            st_d.op   = in_op;
            st_d.dst  = in_dst;
            st_d.srca = in_srca;
            st_d.srcb = in_srcb;
        end else if (st_q.busy && out_ready) begin
            if (last_c) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + VL_W'(LANES);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = st_q.busy;
    assign last      = last_c;
    assign cnt       = st_q.cnt;
    assign vl        = st_q.vl;
    assign op        = st_q.op;
    assign dst_base  = st_q.dst;
    assign srca_base = st_q.srca;
    assign srcb_base = st_q.srcb;
endmodule

// File: rtl/vpack_issue.sv
module vpack_issue #(
    parameter int LANES  = vpack_pkg::LANES_DEF,
    parameter int MAX_VL = vpack_pkg::MAX_VL_DEF,
    parameter int RIDX_W = vpack_pkg::RIDX_W_DEF,
    parameter int OP_W   = vpack_pkg::OP_W_DEF,
    localparam int VL_W   = $clog2(MAX_VL + 1),
    localparam int EIDX_W = $clog2(MAX_VL)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [OP_W-1:0]          in_op,
    input  logic [VL_W-1:0]          in_vl,
    input  logic [RIDX_W-1:0]        in_dst,
    input  logic [RIDX_W-1:0]        in_srca,
    input  logic [RIDX_W-1:0]        in_srcb,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [OP_W-1:0]          out_op,
    output logic                     out_last,
    output logic [LANES-1:0]         slot_valid,
    output logic [LANES*EIDX_W-1:0]  slot_elem,
    output logic [LANES*RIDX_W-1:0]  slot_dst,
    output logic [LANES*RIDX_W-1:0]  slot_srca,
    output logic [LANES*RIDX_W-1:0]  slot_srcb
);
    logic              busy, last;
    logic [VL_W-1:0]   cnt, vl;
    logic [OP_W-1:0]   op;
    logic [RIDX_W-1:0] dst_base, srca_base, srcb_base;

    vpack_ctrl #(
        .LANES(LANES), .VL_W(VL_W), .RIDX_W(RIDX_W), .OP_W(OP_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_vl(in_vl), .in_dst(in_dst), .in_srca(in_srca), .in_srcb(in_srcb),
        .out_ready(out_ready), .busy(busy), .last(last), .cnt(cnt), .vl(vl),
        .op(op), .dst_base(dst_base), .srca_base(srca_base), .srcb_base(srcb_base)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_slot
        vpack_slot #(
            .LANE(k), .VL_W(VL_W), .EIDX_W(EIDX_W), .RIDX_W(RIDX_W)
        ) u_slot (
            .busy(busy), .cnt(cnt), .vl(vl),
            .dst_base(dst_base), .srca_base(srca_base), .srcb_base(srcb_base),
            .valid(slot_valid[k]),
            .elem(slot_elem[k*EIDX_W +: EIDX_W]),
            .dst(slot_dst[k*RIDX_W +: RIDX_W]),
            .srca(slot_srca[k*RIDX_W +: RIDX_W]),
            .srcb(slot_srcb[k*RIDX_W +: RIDX_W])
        );
    end

    assign in_ready  = !busy;
    assign out_valid = busy;
    assign out_last  = last;
    assign out_op    = busy ? op : '0;
endmodule

// File: rtl/vpack_issue_chk.sv
module vpack_issue_chk #(
    parameter int LANES  = 4,
    parameter int EIDX_W = 6
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_ready,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic                    out_last,
    input logic [LANES-1:0]        slot_valid,
    input logic [LANES*EIDX_W-1:0] slot_elem
);
    // R6
    hold_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(slot_elem) && $stable(slot_valid) && $stable(out_last)));

    // R7
    busy_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R4
    inner_group_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |-> (&slot_valid));

    // R2
    group_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=>
            (out_valid && (slot_elem[EIDX_W-1:0] ==
                           $past(slot_elem[EIDX_W-1:0]) + EIDX_W'(LANES))));

    // R10
    slot_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (slot_valid[0] &&
                       ((slot_valid & (slot_valid + LANES'(1))) == '0)));

    // R10
    idle_slots_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (slot_valid == '0));
endmodule

bind vpack_issue vpack_issue_chk #(.LANES(LANES), .EIDX_W(EIDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_last(out_last), .slot_valid(slot_valid),
    .slot_elem(slot_elem)
);

// File: tb/test_vpack_issue.sv
module test_vpack_issue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [3:0]  in_op = '0;
    logic [6:0]  in_vl = '0;
    logic [5:0]  in_dst = '0, in_srca = '0, in_srcb = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [3:0]  out_op;
    logic        out_last;
    logic [3:0]  slot_valid;
    logic [23:0] slot_elem, slot_dst, slot_srca, slot_srcb;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    vpack_issue i_vpack_issue (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_vl(in_vl), .in_dst(in_dst), .in_srca(in_srca),
        .in_srcb(in_srcb), .out_valid(out_valid), .out_ready(out_ready),
        .out_op(out_op), .out_last(out_last), .slot_valid(slot_valid),
        .slot_elem(slot_elem), .slot_dst(slot_dst), .slot_srca(slot_srca),
        .slot_srcb(slot_srcb)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int n_groups(input int vl);
        return (vl + 3) / 4;
    endfunction

    // Issue one descriptor and follow every group it produces.
    task automatic run_desc(input int vl, input int op, input int db, input int ab,
                            input int bb, input int stall_pct, input bit junk);
        int g = 0;
        int ng = n_groups(vl);
        @(negedge clk);
        check(in_ready == 1'b1, "R7 idle before descriptor", in_ready, 1);
        in_valid = 1'b1;
        in_vl = 7'(vl); in_op = 4'(op);
        in_dst = 6'(db); in_srca = 6'(ab); in_srcb = 6'(bb);
        out_ready = 1'b0;
        @(posedge clk);
        #1 in_valid = 1'b0;
        while (g < ng) begin
            @(negedge clk);
            out_ready = (($urandom % 100) >= 32'(stall_pct));
            // conflicting descriptor offered while busy (R7)
            in_valid = junk && ($urandom % 2 == 0);
            in_vl = 7'($urandom % 65); in_op = 4'($urandom);
            in_dst = 6'($urandom); in_srca = 6'($urandom); in_srcb = 6'($urandom);
            #1;
            check(out_valid == 1'b1, "R9 group present", out_valid, 1);
            check(in_ready == 1'b0, "R7 in_ready low while busy", in_ready, 0);
            check(out_op == 4'(op), "R9 opcode tag", out_op, op);
            check(out_last == (g == ng - 1), "R4 last flag", out_last, g == ng - 1);
            for (int k = 0; k < 4; k++) begin
                int e = 4 * g + k;
                bit v = (e < vl);
                check(slot_valid[k] == v, "R4 slot valid", slot_valid[k], v);
                if (v) begin
                    check(slot_elem[k*6 +: 6] == 6'(e), "R2 element index",
                          slot_elem[k*6 +: 6], e);
                    check(slot_dst[k*6 +: 6] == 6'(db + e), "R5 dst index",
                          slot_dst[k*6 +: 6], (db + e) % 64);
                    check(slot_srca[k*6 +: 6] == 6'(ab + e), "R5 srca index",
                          slot_srca[k*6 +: 6], (ab + e) % 64);
                    check(slot_srcb[k*6 +: 6] == 6'(bb + e), "R5 srcb index",
                          slot_srcb[k*6 +: 6], (bb + e) % 64);
                end
            end
            if (out_ready) g++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        out_ready = 1'b0;
        #1;
        check(out_valid == 1'b0, "R9 no extra group", out_valid, 0);
        check(in_ready == 1'b1, "R7 idle after last group", in_ready, 1);
    endtask

    initial begin
        #2_000_000;
        n_fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_checks, 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        check(slot_valid == 4'b0, "R1 slot_valid after reset", slot_valid, 0);
        check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);

        // R8: zero length
        @(negedge clk);
        in_valid = 1'b1; in_vl = '0; in_op = 4'd3;
        @(posedge clk);
        #1 in_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R8 no group for VL=0", out_valid, 0);
        check(in_ready == 1'b1, "R8 in_ready stays high", in_ready, 1);

        // R3: twelve elements, no stalls, three full groups
        run_desc(12, 5, 10, 20, 30, 0, 1'b0);
        // R6: same with heavy stalling
        run_desc(12, 6, 0, 1, 2, 70, 1'b1);
        // R4/R10 corner lengths
        run_desc(1, 1, 63, 62, 61, 20, 1'b0);
        run_desc(3, 2, 5, 5, 5, 20, 1'b1);
        run_desc(4, 7, 60, 0, 33, 0, 1'b0);
        run_desc(5, 8, 1, 2, 3, 40, 1'b1);
        // R9/R5 maximum length with index wraparound
        run_desc(64, 15, 50, 40, 30, 25, 1'b1);

        for (int i = 0; i < 120; i++) begin
            run_desc(int'($urandom % 65) == 0 ? 1 : int'($urandom % 65),
                     int'($urandom % 16), int'($urandom % 64),
                     int'($urandom % 64), int'($urandom % 64),
                     int'($urandom % 60), 1'($urandom));
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule